// File: doc/BRIEF.md
# Miss Status Holding Register File

This block tracks cache misses that are still waiting on the next memory level, so the cache can go on serving hits, and take further misses, while earlier ones are in flight. For each miss the cache presents the block address, the cache frame it has chosen to receive the block, and a requester identifier. The block accepts the miss into a free entry, joins it to an entry already pending for the same block address, or refuses it. A refusal names its cause so that the cache can stall and retry.

Each accepted entry sends one request to the next level, tagged with the entry index. Fill responses carry that tag back and may arrive in any order. When a response completes, the block presents the frame to write, the block address and the list of requesters to notify. The entry is released in the same cycle.

The accept/refuse answer is combinational in the cycle the miss is presented. The request interface is a valid/ready handshake. The fill response is a single-cycle valid with a tag.

Top module: `mshr_file`

## Requirements
- R1: After reset no entry is live: `req_valid` and `fill_valid` are 0, and a miss to any address and frame is granted at index 0.
- R2: A miss that matches no live block address and no live target frame is granted (`alloc_grant`=1, `alloc_merge`=0) into the lowest-numbered free entry, and that index is shown on `alloc_idx`.
- R3: A miss that matches no live address and no live frame while all `N_ENT` entries are valid is refused with `alloc_full`=1.
- R4: A miss whose frame equals the frame of any live entry, and whose address matches no live entry, is refused with `alloc_conflict`=1. This check takes priority over R3.
- R5: A miss whose block address equals that of a live entry holding fewer than `MAX_RID` requesters is merged: `alloc_grant`=1, `alloc_merge`=1, and `alloc_idx` is that entry. The requester is appended and no new request is sent. Its frame is ignored.
- R6: A miss whose block address equals that of a live entry already holding `MAX_RID` requesters is refused with `alloc_overflow`=1.
- R7: `req_valid` is 1 while some valid entry has not yet been sent. `req_tag` is the lowest such index and `req_addr` is its block address. An entry counts as sent at a clock edge where `req_valid` and `req_ready` are both 1.
- R8: A response whose `rsp_tag` names a valid, already-sent entry raises `fill_valid` in the same cycle. With it the block shows the entry's frame and address on `fill_frame` and `fill_addr`, and its requester count on `fill_nrid`. Requester k (in arrival order) is on `fill_rids[k*RID_W +: RID_W]`. The entry is invalid from the next cycle.
- R9: Responses may complete sent entries in any order. Each one reports the data of the entry its tag names.
- R10: An entry completing in a cycle is not counted for address match or frame conflict in that cycle. Its slot is still not free in that cycle, so it can be granted from the next cycle on.
- R11: A response whose tag names an invalid entry, or an entry not yet sent, is ignored: `fill_valid` stays 0 and the entry state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | A miss is presented this cycle |
| alloc_addr | input | ADDR_W | Block address of the miss |
| alloc_frame | input | FRAME_W | Cache frame chosen to receive the block |
| alloc_rid | input | RID_W | Requester identifier |
| alloc_grant | output | 1 | Miss accepted (new entry or merge) |
| alloc_merge | output | 1 | Acceptance was a merge into a live entry |
| alloc_idx | output | IDX_W | Entry index used by an accepted miss |
| alloc_full | output | 1 | Refused: no free entry |
| alloc_conflict | output | 1 | Refused: frame already targeted by a live entry |
| alloc_overflow | output | 1 | Refused: matching entry has no requester slot left |
| req_valid | output | 1 | Next-level request pending |
| req_ready | input | 1 | Next level takes the request |
| req_tag | output | IDX_W | Entry index carried with the request |
| req_addr | output | ADDR_W | Block address requested |
| rsp_valid | input | 1 | Fill response arrives |
| rsp_tag | input | IDX_W | Entry index of the response |
| fill_valid | output | 1 | A fill completes this cycle |
| fill_frame | output | FRAME_W | Frame to install the block into |
| fill_addr | output | ADDR_W | Block address being filled |
| fill_nrid | output | CNT_W | Number of requesters to notify |
| fill_rids | output | MAX_RID*RID_W | Requester identifiers, slot 0 first |

## Verification
The bench builds the block with its defaults: four entries, two requester slots, 8-bit addresses and 3-bit frames. Random misses are drawn from a pool of six block addresses and five frames. With so few entries and such narrow fields, fills, merges, overflows, frame conflicts and the full condition all occur every few cycles, and often together in one cycle. This brings into reach the R10 interplay between a completing entry and a new miss, and stray or early responses under R11. A directed prologue forces each refusal cause and an out-of-order completion in a known order.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

   typedef enum logic [2:0] {
      RES_IDLE,
      RES_NEW,
      RES_MERGE,
      RES_OVER,
      RES_CONFLICT,
      RES_FULL
   } alloc_res_e;

   // Address match outranks frame conflict, which outranks lack of space.
   function automatic alloc_res_e resolve_alloc(
      input logic present,
      input logic addr_any,
      input logic has_room,
      input logic frame_any,
      input logic free_any);
      if (!present)       return RES_IDLE;
      else if (addr_any)  return has_room ? RES_MERGE : RES_OVER;
      else if (frame_any) return RES_CONFLICT;
      else if (!free_any) return RES_FULL;
      else                return RES_NEW;
   endfunction

endpackage

// File: rtl/mshr_prio.sv
module mshr_prio #(
   parameter int WIDTH = 4,
   localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [WIDTH-1:0] vec,
   output logic             any,
   output logic [IW-1:0]    idx
);

   initial begin
      if (WIDTH < 2) $error("mshr_prio: WIDTH must be at least 2");
   end

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (vec[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end

endmodule

// File: rtl/mshr_match.sv
module mshr_match #(
   parameter int N_ENT   = 4,
   parameter int ADDR_W  = 8,
   parameter int FRAME_W = 3
) (
   input  logic [N_ENT-1:0]         live,
   input  logic [N_ENT*ADDR_W-1:0]  ent_addr_flat,
   input  logic [N_ENT*FRAME_W-1:0] ent_frame_flat,
   input  logic [ADDR_W-1:0]        q_addr,
   input  logic [FRAME_W-1:0]       q_frame,
   output logic [N_ENT-1:0]         addr_hit,
   output logic [N_ENT-1:0]         frame_hit
);

   for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
      assign addr_hit[i]  = live[i] &&
                            (ent_addr_flat[i*ADDR_W +: ADDR_W] == q_addr);
      assign frame_hit[i] = live[i] &&
                            (ent_frame_flat[i*FRAME_W +: FRAME_W] == q_frame);
   end

endmodule

// File: rtl/mshr_file.sv
module mshr_file
   import mshr_pkg::*;
#(
   parameter int N_ENT   = 4,
   parameter int ADDR_W  = 8,
   parameter int FRAME_W = 3,
   parameter int RID_W   = 4,
   parameter int MAX_RID = 2,
   localparam int IDX_W  = $clog2(N_ENT),
   localparam int CNT_W  = $clog2(MAX_RID + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     alloc_valid,
   input  logic [ADDR_W-1:0]        alloc_addr,
   input  logic [FRAME_W-1:0]       alloc_frame,
   input  logic [RID_W-1:0]         alloc_rid,
   output logic                     alloc_grant,
   output logic                     alloc_merge,
   output logic [IDX_W-1:0]         alloc_idx,
   output logic                     alloc_full,
   output logic                     alloc_conflict,
   output logic                     alloc_overflow,
   output logic                     req_valid,
   input  logic                     req_ready,
   output logic [IDX_W-1:0]         req_tag,
   output logic [ADDR_W-1:0]        req_addr,
   input  logic                     rsp_valid,
   input  logic [IDX_W-1:0]         rsp_tag,
   output logic                     fill_valid,
   output logic [FRAME_W-1:0]       fill_frame,
   output logic [ADDR_W-1:0]        fill_addr,
   output logic [CNT_W-1:0]         fill_nrid,
   output logic [MAX_RID*RID_W-1:0] fill_rids
);

   // elaboration-time parameter checks
   if (N_ENT < 2 || (1 << IDX_W) != N_ENT) begin : g_bad_nent
      $error("mshr_file: N_ENT must be a power of two, at least 2");
   end
   if (MAX_RID < 1) begin : g_bad_rid
      $error("mshr_file: MAX_RID must be at least 1");
   end

   // entry state
   logic [N_ENT-1:0]   ent_vld, ent_sent;
   logic [ADDR_W-1:0]  ent_addr  [N_ENT];
   logic [FRAME_W-1:0] ent_frame [N_ENT];
   logic [CNT_W-1:0]   ent_cnt   [N_ENT];
   logic [RID_W-1:0]   ent_rid   [N_ENT][MAX_RID];

   logic [N_ENT*ADDR_W-1:0]  addr_flat;
   logic [N_ENT*FRAME_W-1:0] frame_flat;
   for (genvar i = 0; i < N_ENT; i++) begin : g_flat
      assign addr_flat[i*ADDR_W +: ADDR_W]    = ent_addr[i];
      assign frame_flat[i*FRAME_W +: FRAME_W] = ent_frame[i];
   end

   // fill completion
   logic             rsp_hit;
   logic [N_ENT-1:0] done_vec, live;
   assign rsp_hit  = rsp_valid && ent_vld[rsp_tag] && ent_sent[rsp_tag];
   assign done_vec = rsp_hit ? (N_ENT'(1) << rsp_tag) : '0;
   assign live     = ent_vld & ~done_vec;

   assign fill_valid = rsp_hit;
   assign fill_frame = ent_frame[rsp_tag];
   assign fill_addr  = ent_addr[rsp_tag];
   assign fill_nrid  = ent_cnt[rsp_tag];
   for (genvar k = 0; k < MAX_RID; k++) begin : g_fill_rid
      assign fill_rids[k*RID_W +: RID_W] = ent_rid[rsp_tag][k];
   end

   // allocation search
   logic [N_ENT-1:0] addr_hit, frame_hit;
   logic             hit_any, free_any;
   logic [IDX_W-1:0] hit_idx, free_idx;

   mshr_match #(.N_ENT(N_ENT), .ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) u_match (
      .live           (live),
      .ent_addr_flat  (addr_flat),
      .ent_frame_flat (frame_flat),
      .q_addr         (alloc_addr),
      .q_frame        (alloc_frame),
      .addr_hit       (addr_hit),
      .frame_hit      (frame_hit)
   );

   mshr_prio #(.WIDTH(N_ENT)) u_hit_pick (
      .vec (addr_hit), .any (hit_any), .idx (hit_idx));

   mshr_prio #(.WIDTH(N_ENT)) u_free_pick (
      .vec (~ent_vld), .any (free_any), .idx (free_idx));

   alloc_res_e res;
   assign res = resolve_alloc(alloc_valid, hit_any,
                              ent_cnt[hit_idx] < CNT_W'(MAX_RID),
                              |frame_hit, free_any);

   assign alloc_grant    = (res == RES_NEW) || (res == RES_MERGE);
   assign alloc_merge    = (res == RES_MERGE);
   assign alloc_idx      = (res == RES_MERGE) ? hit_idx : free_idx;
   assign alloc_full     = (res == RES_FULL);
   assign alloc_conflict = (res == RES_CONFLICT);
   assign alloc_overflow = (res == RES_OVER);

   // next-level request
   mshr_prio #(.WIDTH(N_ENT)) u_req_pick (
      .vec (ent_vld & ~ent_sent), .any (req_valid), .idx (req_tag));
   assign req_addr = ent_addr[req_tag];

   // state update
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_vld  <= '0;
         ent_sent <= '0;
         for (int i = 0; i < N_ENT; i++) begin
            ent_addr[i]  <= '0;
            ent_frame[i] <= '0;
            ent_cnt[i]   <= '0;
            for (int k = 0; k < MAX_RID; k++) ent_rid[i][k] <= '0;
         end
      end else begin
         for (int i = 0; i < N_ENT; i++) begin
            if (done_vec[i]) begin
               ent_vld[i]  <= 1'b0;
               ent_sent[i] <= 1'b0;
            end
            if (req_valid && req_ready && req_tag == IDX_W'(i))
               ent_sent[i] <= 1'b1;
            if (res == RES_NEW && free_idx == IDX_W'(i)) begin
               ent_vld[i]    <= 1'b1;
               ent_sent[i]   <= 1'b0;
               ent_addr[i]   <= alloc_addr;
               ent_frame[i]  <= alloc_frame;
               ent_cnt[i]    <= CNT_W'(1);
               ent_rid[i][0] <= alloc_rid;
            end
            if (res == RES_MERGE && hit_idx == IDX_W'(i)) begin
               ent_cnt[i] <= ent_cnt[i] + CNT_W'(1);
               for (int k = 0; k < MAX_RID; k++)
                  if (ent_cnt[i] == CNT_W'(k)) ent_rid[i][k] <= alloc_rid;
            end
         end
      end
   end

   // assertions
   a_r8_freed_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |=> !ent_vld[$past(rsp_tag)]);

   a_r10_no_same_cycle_reuse: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && alloc_grant && !alloc_merge) |-> (alloc_idx != rsp_tag));

   a_r3_full_only_when_all_valid: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_full |-> (&ent_vld));

   a_r5_single_address_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(addr_hit));

   a_r5_merge_keeps_population: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_merge && !fill_valid) |=> ($countones(ent_vld) == $past($countones(ent_vld))));

   a_r11_stray_keeps_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !fill_valid && ent_vld[rsp_tag]) |=> ent_vld[$past(rsp_tag)]);

   for (genvar i = 0; i < N_ENT; i++) begin : g_chk
      a_r6_requester_cap: assert property (@(posedge clk) disable iff (!rst_n)
         ent_cnt[i] <= CNT_W'(MAX_RID));
   end

endmodule

// File: tb/mshr_file_test.sv
module mshr_file_test;

   localparam int N_ENT = 4, ADDR_W = 8, FRAME_W = 3, RID_W = 4, MAX_RID = 2;
   localparam int IDX_W = 2, CNT_W = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic                     alloc_valid = 1'b0;
   logic [ADDR_W-1:0]        alloc_addr = '0;
   logic [FRAME_W-1:0]       alloc_frame = '0;
   logic [RID_W-1:0]         alloc_rid = '0;
   logic                     alloc_grant, alloc_merge, alloc_full;
   logic                     alloc_conflict, alloc_overflow;
   logic [IDX_W-1:0]         alloc_idx;
   logic                     req_valid;
   logic                     req_ready = 1'b0;
   logic [IDX_W-1:0]         req_tag;
   logic [ADDR_W-1:0]        req_addr;
   logic                     rsp_valid = 1'b0;
   logic [IDX_W-1:0]         rsp_tag = '0;
   logic                     fill_valid;
   logic [FRAME_W-1:0]       fill_frame;
   logic [ADDR_W-1:0]        fill_addr;
   logic [CNT_W-1:0]         fill_nrid;
   logic [MAX_RID*RID_W-1:0] fill_rids;

   mshr_file #(.N_ENT(N_ENT), .ADDR_W(ADDR_W), .FRAME_W(FRAME_W),
               .RID_W(RID_W), .MAX_RID(MAX_RID)) uut (
      .clk, .rst_n, .alloc_valid, .alloc_addr, .alloc_frame, .alloc_rid,
      .alloc_grant, .alloc_merge, .alloc_idx, .alloc_full, .alloc_conflict,
      .alloc_overflow, .req_valid, .req_ready, .req_tag, .req_addr,
      .rsp_valid, .rsp_tag, .fill_valid, .fill_frame, .fill_addr,
      .fill_nrid, .fill_rids);

   int errors = 0;
   int checks = 0;

   // reference model state
   bit       m_vld [N_ENT];
   bit       m_sent[N_ENT];
   int       m_addr[N_ENT];
   int       m_frm [N_ENT];
   int       m_cnt [N_ENT];
   int       m_rid [N_ENT][MAX_RID];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // expected outcome kinds: 0 idle,1 new,2 merge,3 over,4 conflict,5 full
   task automatic eval_and_update();
      bit done;
      int hit, fr, rq, kind, idx;
      bit fc;
      done = rsp_valid && m_vld[rsp_tag] && m_sent[rsp_tag];
      hit = -1; fc = 0; fr = -1; rq = -1;
      for (int i = 0; i < N_ENT; i++) begin
         bit lv;
         lv = m_vld[i] && !(done && rsp_tag == i);
         if (lv && m_addr[i] == int'(alloc_addr) && hit < 0) hit = i;
         if (lv && m_frm[i] == int'(alloc_frame)) fc = 1;
         if (!m_vld[i] && fr < 0) fr = i;
         if (m_vld[i] && !m_sent[i] && rq < 0) rq = i;
      end
      if (!alloc_valid)   kind = 0;
      else if (hit >= 0)  kind = (m_cnt[hit] < MAX_RID) ? 2 : 3;
      else if (fc)        kind = 4;
      else if (fr < 0)    kind = 5;
      else                kind = 1;
      idx = (kind == 2) ? hit : fr;

      chk(alloc_grant == (kind == 1 || kind == 2), "R2 grant", alloc_grant, int'(kind == 1 || kind == 2));
      if (kind == 1 || kind == 2)
         chk(int'(alloc_idx) == idx, "R2 index", alloc_idx, idx);
      chk(alloc_merge == (kind == 2), "R5 merge", alloc_merge, int'(kind == 2));
      chk(alloc_overflow == (kind == 3), "R6 overflow", alloc_overflow, int'(kind == 3));
      chk(alloc_conflict == (kind == 4), "R4 conflict", alloc_conflict, int'(kind == 4));
      chk(alloc_full == (kind == 5), "R3 full", alloc_full, int'(kind == 5));
      chk(req_valid == (rq >= 0), "R7 req_valid", req_valid, int'(rq >= 0));
      if (rq >= 0) begin
         chk(int'(req_tag) == rq, "R7 req_tag", req_tag, rq);
         chk(int'(req_addr) == m_addr[rq], "R7 req_addr", req_addr, m_addr[rq]);
      end
      chk(fill_valid == done, "R8 fill_valid", fill_valid, int'(done));
      if (done) begin
         chk(int'(fill_frame) == m_frm[rsp_tag], "R8 fill_frame", fill_frame, m_frm[rsp_tag]);
         chk(int'(fill_addr) == m_addr[rsp_tag], "R8 fill_addr", fill_addr, m_addr[rsp_tag]);
         chk(int'(fill_nrid) == m_cnt[rsp_tag], "R8 fill_nrid", fill_nrid, m_cnt[rsp_tag]);
         for (int k = 0; k < MAX_RID; k++)
            if (k < m_cnt[rsp_tag])
               chk(int'(fill_rids[k*RID_W +: RID_W]) == m_rid[rsp_tag][k], "R8 fill_rids",
                   fill_rids[k*RID_W +: RID_W], m_rid[rsp_tag][k]);
      end

      // next state
      if (done) begin m_vld[rsp_tag] = 0; m_sent[rsp_tag] = 0; end
      if (rq >= 0 && req_ready) m_sent[rq] = 1;
      if (kind == 1) begin
         m_vld[fr] = 1; m_sent[fr] = 0; m_addr[fr] = int'(alloc_addr);
         m_frm[fr] = int'(alloc_frame); m_cnt[fr] = 1; m_rid[fr][0] = int'(alloc_rid);
      end
      if (kind == 2) begin
         m_rid[hit][m_cnt[hit]] = int'(alloc_rid);
         m_cnt[hit]++;
      end
   endtask

   task automatic step(input bit av, input int a, input int f, input int r,
                       input bit rdy, input bit rv, input int t);
      @(negedge clk);
      alloc_valid = av; alloc_addr = ADDR_W'(a); alloc_frame = FRAME_W'(f);
      alloc_rid = RID_W'(r); req_ready = rdy; rsp_valid = rv; rsp_tag = IDX_W'(t);
      #1;
      eval_and_update();
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired (no requirement completed)");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < N_ENT; i++) begin
         m_vld[i] = 0; m_sent[i] = 0; m_addr[i] = 0; m_frm[i] = 0; m_cnt[i] = 0;
         for (int k = 0; k < MAX_RID; k++) m_rid[i][k] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: empty after reset
      step(0, 0, 0, 0, 0, 0, 0);
      chk(req_valid == 0, "R1 req_valid", req_valid, 0);
      chk(fill_valid == 0, "R1 fill_valid", fill_valid, 0);
      step(1, 'h20, 0, 1, 0, 0, 0);
      chk(alloc_grant && alloc_idx == 0, "R1 first grant index", alloc_idx, 0);
      step(1, 'h21, 1, 2, 0, 0, 0);
      step(1, 'h22, 2, 3, 0, 0, 0);
      step(1, 'h23, 3, 4, 0, 0, 0);
      chk(alloc_idx == 3, "R2 lowest free", alloc_idx, 3);
      step(1, 'h30, 5, 7, 0, 0, 0);
      chk(alloc_full == 1, "R3 full", alloc_full, 1);
      step(1, 'h31, 1, 7, 0, 0, 0);
      chk(alloc_conflict == 1 && alloc_full == 0, "R4 conflict over full", alloc_conflict, 1);
      step(1, 'h21, 6, 5, 0, 0, 0);
      chk(alloc_merge == 1 && alloc_idx == 1, "R5 merge into entry 1", alloc_idx, 1);
      step(1, 'h21, 1, 6, 0, 0, 0);
      chk(alloc_overflow == 1, "R6 overflow", alloc_overflow, 1);
      // R11: response to an entry not yet sent
      step(0, 0, 0, 0, 0, 1, 2);
      chk(fill_valid == 0, "R11 unsent tag ignored", fill_valid, 0);
      for (int k = 0; k < N_ENT; k++) begin
         step(0, 0, 0, 0, 1, 0, 0);
         chk(req_valid && req_tag == IDX_W'(k), "R7 request order", req_tag, k);
      end
      // R9 / R10: entry 3 completes first; its slot is not reused that cycle
      step(1, 'h40, 4, 8, 0, 1, 3);
      chk(fill_valid && fill_addr == 8'h23, "R9 out-of-order fill", fill_addr, 'h23);
      chk(alloc_full == 1, "R10 freed slot not reused", alloc_full, 1);
      step(1, 'h40, 4, 8, 0, 0, 0);
      chk(alloc_grant && alloc_idx == 3, "R10 slot reused next cycle", alloc_idx, 3);
      step(0, 0, 0, 0, 0, 1, 3);
      chk(fill_valid == 0, "R11 unsent reallocated tag", fill_valid, 0);
      // R10: completing entry 1 does not count for address match
      step(1, 'h21, 7, 9, 0, 1, 1);
      chk(fill_nrid == 2 && fill_rids[RID_W +: RID_W] == 4'd5, "R8 merged requester",
          fill_rids[RID_W +: RID_W], 5);
      chk(alloc_full == 1 && alloc_overflow == 0, "R10 completing entry excluded", alloc_full, 1);
      step(0, 0, 0, 0, 0, 1, 1);
      chk(fill_valid == 0, "R11 invalid tag ignored", fill_valid, 0);

      // constrained random phase
      for (int c = 0; c < 4000; c++) begin
         int t, off;
         t = int'($urandom % N_ENT);
         if ($urandom % 5 != 0) begin
            off = int'($urandom % N_ENT);
            for (int j = 0; j < N_ENT; j++)
               if (m_vld[(off + j) % N_ENT] && m_sent[(off + j) % N_ENT])
                  t = (off + j) % N_ENT;
         end
         step(($urandom % 4) != 0, 'h10 + int'($urandom % 6) * 'h11, int'($urandom % 5),
              int'($urandom % 16), ($urandom % 3) != 0, ($urandom % 3) == 0, t);
      end

      summary();
      $finish;
   end

endmodule